// File: doc/BRIEF.md
# Square-Wave Output and Oscillator Stop Flag Controller

This block holds the control byte of a timekeeping unit and drives the level of an open-drain square-wave pin. A strobe arrives once per half cycle of a 32.768 kHz crystal, so there are 65,536 strobes per second. A single 16-bit prescaler counts these strobes. Its bits supply four square-wave rates (1 Hz, 4.096 kHz, 8.192 kHz and 32.768 kHz), and because every rate comes from the same counter, all of them stay phase-aligned. When the square wave is disabled, the pin holds a static level chosen by software.

The timekeeping core sends a clear pulse when the seconds register is written. That pulse zeroes the prescaler, so the 1 Hz output rises exactly half a second later. A watchdog runs on the system clock and watches the strobe. When strobes stop arriving, or when the core's halt bit is set, the watchdog raises a sticky oscillator-stop flag. Software can clear that flag but can never set it.

Top module: `sqw_ctrl`

## Requirements
- R1: After reset the control byte reads 0xB3 and `sqw_out` is 0.
- R2: The control byte read value is {out[7], 0, stop_flag[5], wave_en[4], 0, 0, rate[1:0]}. Bits 6, 3 and 2 always read 0, whatever value is written.
- R3: With wave_en=1, the rate code selects a half period in strobes: code 0 gives 32768 (1 Hz), code 1 gives 8 (4.096 kHz), code 2 gives 4 (8.192 kHz) and code 3 gives 1 (32.768 kHz). After n strobes counted from a prescaler clear, the pin is ((n / half) mod 2), and it appears one clock after the counting strobe.
- R4: With wave_en=0, `sqw_out` equals the out bit one clock later, and strobes have no effect on it.
- R5: Writing 0 to bit 5 clears the stop flag. Writing 1 to bit 5 leaves the flag unchanged.
- R6: Once the strobe has been running, the flag sets on the clock that follows STOP_LIMIT system clocks with no strobe. It sets only once per stop, so a clear written while the strobe is still absent stays cleared.
- R7: A rise of `halt` while the strobe is running sets the stop flag on the next clock, without waiting for the watchdog.
- R8: A `presc_clr` pulse zeroes the prescaler, which drives every rate low. With code 0 the pin rises on the 32768th strobe after the clear.
- R9: While `halt` is 1, strobes do not advance the prescaler and the wave output keeps its level, even if the rate code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_strobe | input | 1 | One-cycle pulse per oscillator half cycle |
| halt | input | 1 | Clock halt bit from the timekeeping core |
| presc_clr | input | 1 | Prescaler clear pulse on a seconds write |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| ctl_rd | output | 8 | Control byte read value |
| sqw_out | output | 1 | Level for the open-drain square-wave pin |

## Verification
The assertions assume that `osc_strobe`, `presc_clr` and `wr_en` are synchronous single-cycle pulses, and that `presc_clr` never coincides with a strobe unless the clear is meant to win. The stimulus drives every input on the falling clock edge. It issues each pulse for exactly one cycle, and it keeps gaps between strobes well below STOP_LIMIT except where a stop is intended. The halt assertions rely on `halt` being a level that is held for many cycles, and the bench only ever toggles it between whole scenarios.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  localparam int unsigned CTL_BIT_OUT  = 7;
  localparam int unsigned CTL_BIT_STOP = 5;
  localparam int unsigned CTL_BIT_WAVE = 4;

  typedef enum logic [1:0] {
    RATE_1HZ  = 2'd0,
    RATE_4K   = 2'd1,
    RATE_8K   = 2'd2,
    RATE_32K  = 2'd3
  } rate_e;

  typedef struct packed {
    logic  out;
    logic  stop_flag;
    logic  wave_en;
    rate_e rate;
  } ctl_t;

  localparam ctl_t CTL_POR = '{out: 1'b1, stop_flag: 1'b1, wave_en: 1'b1, rate: RATE_32K};

  function automatic logic [7:0] ctl_pack(ctl_t c);
    logic [7:0] b;
    b = 8'h00;
    b[CTL_BIT_OUT]  = c.out;
    b[CTL_BIT_STOP] = c.stop_flag;
    b[CTL_BIT_WAVE] = c.wave_en;
    b[1:0]          = c.rate;
    return b;
  endfunction

  function automatic ctl_t ctl_write(ctl_t cur, logic [7:0] d);
    ctl_t n;
    n.out       = d[CTL_BIT_OUT];
    n.stop_flag = cur.stop_flag & d[CTL_BIT_STOP];
    n.wave_en   = d[CTL_BIT_WAVE];
    n.rate      = rate_e'(d[1:0]);
    return n;
  endfunction

  function automatic int unsigned rate_tap(int unsigned code, int unsigned cnt_w,
                                           int unsigned tap_4k, int unsigned tap_8k,
                                           int unsigned tap_32k);
    case (code)
      0:       return cnt_w - 1;
      1:       return tap_4k;
      2:       return tap_8k;
      default: return tap_32k;
    endcase
  endfunction

endpackage

// File: rtl/sqw_prescaler.sv
module sqw_prescaler #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TAP_4K  = 3,
  parameter int unsigned TAP_8K  = 2,
  parameter int unsigned TAP_32K = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic [3:0]       taps
);
  import sqw_pkg::*;

  localparam int unsigned NUM_RATES = 4;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
    localparam int unsigned POS = rate_tap(g, CNT_W, TAP_4K, TAP_8K, TAP_32K);
    assign taps[g] = cnt_q[POS];
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/sqw_stop_detect.sv
module sqw_stop_detect #(
  parameter int unsigned STOP_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic halt,
  output logic stop_evt,
  output logic stopped
);
  localparam int unsigned WD_W = $clog2(STOP_LIMIT + 1);
  localparam logic [WD_W-1:0] WD_MAX = WD_W'(STOP_LIMIT);

  logic [WD_W-1:0] wd_q;
  logic            expired;
  logic            stopped_now;
  logic            stopped_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wd_q <= WD_MAX;
    else if (strobe)         wd_q <= '0;
    else if (wd_q != WD_MAX) wd_q <= wd_q + 1'b1;
  end

  assign expired     = (wd_q == WD_MAX);
  assign stopped_now = expired | halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stopped_q <= 1'b1;
    else        stopped_q <= stopped_now;
  end

  assign stop_evt = stopped_now & ~stopped_q;
  assign stopped  = stopped_q;
endmodule

// File: rtl/sqw_ctl_reg.sv
module sqw_ctl_reg (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [7:0]     wr_data,
  input  logic           set_stop,
  output sqw_pkg::ctl_t  ctl,
  output logic [7:0]     rd_data
);
  import sqw_pkg::*;

  ctl_t ctl_q;
  ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en)    ctl_d = ctl_write(ctl_q, wr_data);
    if (set_stop) ctl_d.stop_flag = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_POR;
    else        ctl_q <= ctl_d;
  end

  assign ctl     = ctl_q;
  assign rd_data = ctl_pack(ctl_q);
endmodule

// File: rtl/sqw_out_stage.sv
module sqw_out_stage (
  input  logic          clk,
  input  logic          rst_n,
  input  sqw_pkg::ctl_t ctl,
  input  logic          halt,
  input  logic [3:0]    taps,
  output logic          pin
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pin_q <= 1'b0;
    else if (!ctl.wave_en) pin_q <= ctl.out;
    else if (!halt)        pin_q <= taps[ctl.rate];
  end

  assign pin = pin_q;
endmodule

// File: rtl/sqw_ctrl.sv
module sqw_ctrl #(
  parameter int unsigned PRESC_W    = 16,
  parameter int unsigned TAP_4K     = 3,
  parameter int unsigned TAP_8K     = 2,
  parameter int unsigned TAP_32K    = 0,
  parameter int unsigned STOP_LIMIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_strobe,
  input  logic       halt,
  input  logic       presc_clr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] ctl_rd,
  output logic       sqw_out
);
  import sqw_pkg::*;

  logic               stop_evt;
  logic               stopped_q;
  logic               presc_adv;
  logic [PRESC_W-1:0] presc_cnt;
  logic [3:0]         rate_taps;
  ctl_t               ctl;
  logic               stop_bit;
  logic               wave_bit;
  logic               out_bit;

  assign presc_adv = osc_strobe & ~halt;

  sqw_prescaler #(
    .CNT_W(PRESC_W), .TAP_4K(TAP_4K), .TAP_8K(TAP_8K), .TAP_32K(TAP_32K)
  ) presc_i (
    .clk(clk), .rst_n(rst_n), .adv(presc_adv), .clr(presc_clr),
    .cnt(presc_cnt), .taps(rate_taps)
  );

  sqw_stop_detect #(.STOP_LIMIT(STOP_LIMIT)) stop_i (
    .clk(clk), .rst_n(rst_n), .strobe(osc_strobe), .halt(halt),
    .stop_evt(stop_evt), .stopped(stopped_q)
  );

  sqw_ctl_reg reg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .set_stop(stop_evt), .ctl(ctl), .rd_data(ctl_rd)
  );

  sqw_out_stage out_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .halt(halt),
    .taps(rate_taps), .pin(sqw_out)
  );

  assign stop_bit = ctl.stop_flag;
  assign wave_bit = ctl.wave_en;
  assign out_bit  = ctl.out;
endmodule

// File: rtl/sqw_ctrl_chk.sv
module sqw_ctrl_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt,
  input logic             presc_clr,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic             stop_evt,
  input logic             stopped,
  input logic             stop_bit,
  input logic             wave_bit,
  input logic             out_bit,
  input logic             sqw_out,
  input logic [CNT_W-1:0] cnt
);
  // R6
  stop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> stop_bit);

  // R5
  flag_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_bit && !stop_evt) |=> !stop_bit);

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[5] && !stop_evt) |=> !stop_bit);

  // R4
  static_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wave_bit |=> (sqw_out == $past(out_bit)));

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && wave_bit) |=> $stable(sqw_out));

  // R9
  halt_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !presc_clr) |=> $stable(cnt));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    presc_clr |=> (cnt == '0));

  // R7
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !stopped) |-> stop_evt);
endmodule

bind sqw_ctrl sqw_ctrl_chk #(.CNT_W(PRESC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .halt(halt), .presc_clr(presc_clr),
  .wr_en(wr_en), .wr_data(wr_data), .stop_evt(stop_evt), .stopped(stopped_q),
  .stop_bit(stop_bit), .wave_bit(wave_bit), .out_bit(out_bit),
  .sqw_out(sqw_out), .cnt(presc_cnt)
);

// File: tb/sqw_ctrl_tb_top.sv
module sqw_ctrl_tb_top;
  localparam int unsigned LIMIT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_strobe = 1'b0;
  logic       halt = 1'b0;
  logic       presc_clr = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctl_rd;
  logic       sqw_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sqw_ctrl #(.STOP_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_strobe(osc_strobe), .halt(halt),
    .presc_clr(presc_clr), .wr_en(wr_en), .wr_data(wr_data),
    .ctl_rd(ctl_rd), .sqw_out(sqw_out)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_strobe();
    @(negedge clk) osc_strobe = 1'b1;
    @(negedge clk) osc_strobe = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) presc_clr = 1'b1;
    @(negedge clk) presc_clr = 1'b0;
  endtask

  task automatic write_ctl(logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  function automatic logic exp_level(int unsigned n, int unsigned half);
    return logic'((n / half) % 2);
  endfunction

  task automatic t_reset();
    check("R1 reset byte", ctl_rd, 8'hB3);
    check("R1 reset pin", {7'd0, sqw_out}, 8'h00);
  endtask

  task automatic t_register();
    write_ctl(8'hFF);
    check("R2 reserved bits read zero", ctl_rd, 8'hB3);
    write_ctl(8'h00);
    check("R5 flag cleared by zero", ctl_rd, 8'h00);
    write_ctl(8'h20);
    check("R5 writing one keeps flag low", ctl_rd, 8'h00);
    write_ctl(8'hFF);
    check("R2 byte after full write", ctl_rd, 8'h93);
  endtask

  task automatic t_static();
    write_ctl(8'h80);
    idle(1);
    check("R4 static high", {7'd0, sqw_out}, 8'h01);
    for (int i = 0; i < 3; i++) pulse_strobe();
    idle(1);
    check("R4 strobes ignored", {7'd0, sqw_out}, 8'h01);
    write_ctl(8'h00);
    idle(1);
    check("R4 static low", {7'd0, sqw_out}, 8'h00);
  endtask

  task automatic t_rates();
    int unsigned halves[4] = '{32768, 8, 4, 1};
    for (int code = 1; code < 4; code++) begin
      write_ctl(8'h10 | 8'(code));
      pulse_clr();
      idle(1);
      check("R8 clear drives rate low", {7'd0, sqw_out}, 8'h00);
      for (int unsigned n = 1; n <= 20; n++) begin
        pulse_strobe();
        idle(1);
        check("R3 rate waveform", {7'd0, sqw_out}, {7'd0, exp_level(n, halves[code])});
      end
    end
  endtask

  task automatic t_one_hz();
    write_ctl(8'h10);
    pulse_clr();
    for (int i = 0; i < 32767; i++) pulse_strobe();
    idle(1);
    check("R8 1Hz low before half second", {7'd0, sqw_out}, 8'h00);
    pulse_strobe();
    idle(1);
    check("R8 1Hz high at half second", {7'd0, sqw_out}, 8'h01);
  endtask

  task automatic t_stop();
    for (int i = 0; i < 3; i++) pulse_strobe();
    write_ctl(8'h13);
    write_ctl(8'h03);
    check("R5 flag cleared while running", ctl_rd, 8'h03);
    pulse_strobe();
    idle(LIMIT - 2);
    check("R6 flag low before limit", ctl_rd, 8'h03);
    idle(3);
    check("R6 flag set after limit", ctl_rd, 8'h23);
    write_ctl(8'h03);
    idle(3 * LIMIT);
    check("R6 single set per stop", ctl_rd, 8'h03);
    pulse_strobe();
    idle(LIMIT + 3);
    check("R6 flag set on second stop", ctl_rd, 8'h23);
  endtask

  task automatic t_halt();
    write_ctl(8'h13);
    pulse_clr();
    pulse_strobe();
    write_ctl(8'h03 | 8'h10);
    idle(1);
    check("R3 pin after one strobe", {7'd0, sqw_out}, 8'h01);
    check("R7 flag clear before halt", ctl_rd, 8'h13);
    @(negedge clk) halt = 1'b1;
    idle(1);
    check("R7 halt sets flag", ctl_rd, 8'h33);
    for (int i = 0; i < 5; i++) pulse_strobe();
    write_ctl(8'h12);
    idle(2);
    check("R9 pin frozen during halt", {7'd0, sqw_out}, 8'h01);
    write_ctl(8'h13);
    @(negedge clk) halt = 1'b0;
    pulse_strobe();
    idle(1);
    check("R9 count frozen during halt", {7'd0, sqw_out}, 8'h00);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_register();
    t_static();
    t_rates();
    t_one_hz();
    t_stop();
    t_halt();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule